// File: doc/BRIEF.md
# Repetition-Gated Timer Counter

This block is a 16-bit timer counter that runs up, down or center-aligned, paced by a programmable prescaler. Its period, prescaler divider and compare value each live in two copies: a buffered copy that bus writes land in, and an active copy that the counter and downstream logic use. The buffered values move into the active copies only when an update event fires.

Update events are thinned out by an 8-bit repetition counter. Every counter end-of-range (an overflow at the top, an underflow at the bottom, or both in center-aligned mode) decrements it, and an update event fires only at an end-of-range seen while the repetition counter sits at zero. That end-of-range then reloads it from the repetition register, so with a repetition value of N the active registers refresh once every N+1 end-of-range events, with no software help. A software strobe or a request from a slave controller forces an update event at once and restarts the repetition count. Each update event raises a sticky interrupt flag that stays set until it is cleared.

Top module: `rep_timer`

## Requirements
- R1: With `mode` = 2'b00 (up, also used for 2'b11), on each counter step the count goes up by one, and from any value at or above the active period it wraps to 0. That wrap is an end-of-range event.
- R2: With `mode` = 2'b01 (down), on each counter step the count goes down by one, and from 0 it reloads the active period. That reload is an end-of-range event.
- R3: With `mode` = 2'b10 (center), the count climbs from 0 to the active period and then falls back to 0, turning around at each end. The step leaving the top and the step leaving 0 are both end-of-range events.
- R4: The counter takes a step only while `cnt_en` is high, once every (active prescaler + 1) enabled cycles. With `cnt_en` low, the count holds its value. Every update event restarts the prescaler count at zero.
- R5: `upd_o` is high, in the cycle of a counter step, when that step is an end-of-range event and the repetition counter is zero. That event reloads the repetition counter from the repetition register. Any other end-of-range event decrements the repetition counter and produces no update. A repetition value N therefore gives one update every N+1 end-of-range events.
- R6: In center mode both the top and the bottom turnaround decrement the repetition counter. With a repetition value of 1, updates then come once per full up/down cycle.
- R7: A high `sw_update` or `slave_update` drives `upd_o` high in the same cycle, whatever the repetition count is, and reloads the repetition counter from the repetition register.
- R8: Writes with `wr_sel` = 0 (period), 1 (prescaler), 2 (compare) or 3 (repetition) go to the buffered copies. While `period_buf_en` is high, `period_o`, `psc_o` and `cmp_o` change only on an update event, and they then take the buffered values.
- R9: While `period_buf_en` is low, a period write shows on `period_o` in the cycle after the write.
- R10: `uif_o` is set by each update event and stays set until `uif_clr` is high. An update in the same cycle as a clear wins.
- R11: After reset, `count_o` is 0, `uif_o` is 0, `period_o` is all ones, `psc_o` and `cmp_o` are 0, and the repetition value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 prescaler, 2 compare, 3 repetition |
| wr_data | input | 16 | Write data (repetition uses the low 8 bits) |
| period_buf_en | input | 1 | Period writes are buffered until an update |
| mode | input | 2 | Count mode: 00 up, 01 down, 10 center |
| sw_update | input | 1 | Software update-generate strobe |
| slave_update | input | 1 | Update request from a slave controller |
| uif_clr | input | 1 | Clears the update flag |
| count_o | output | 16 | Counter value |
| upd_o | output | 1 | Update event, high for the cycle before it takes effect |
| uif_o | output | 1 | Sticky update flag |
| period_o | output | 16 | Active period |
| psc_o | output | 16 | Active prescaler divider |
| cmp_o | output | 16 | Active compare value |

## Verification
The bench sweeps every count mode over small periods, prescaler values and repetition values, and compares the design with an arithmetic model on every cycle. This catches a design that fires an update on every wrap, that counts only one turnaround in center mode (it would update half as often), or that leaves the prescaler running across an update. Directed cases count updates over fixed windows against closed-form expectations. They check that a buffered period write leaves the active period alone until the next update, that an unbuffered write applies at once, and that a forced update arrives mid-count and restarts the repetition count. They also cover a clear arriving together with an update, where a design that lets the clear win would lose the flag.

// File: rtl/rtmr_pkg.sv
// Shared encodings for the repetition-gated timer.
// Assumes: mode and write-select fields are two bits wide.
package rtmr_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_CENTER = 2'b10,
        MODE_RSVD   = 2'b11
    } cnt_mode_e;

    localparam int FLD_PERIOD = 0;
    localparam int FLD_PSC    = 1;
    localparam int FLD_CMP    = 2;
    localparam int FLD_REP    = 3;
    localparam int N_BUF      = 3;
endpackage

// File: rtl/rtmr_regs.sv
// Buffered and active copies of period, prescaler and compare, plus the
// repetition register. Active copies load from the buffered copy (including a
// write in the same cycle) on an update; the period may bypass buffering.
// Assumes: repetition value uses the low REP_W bits of the write data.
module rtmr_regs
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         period_buf_en,
    input  logic                         upd,
    output logic [N_BUF-1:0][CNT_W-1:0]  act,
    output logic [REP_W-1:0]             rep_val
);
    for (genvar g = 0; g < N_BUF; g++) begin : g_fld
        localparam logic [CNT_W-1:0] RST_VAL = (g == FLD_PERIOD) ? '1 : '0;
        logic [CNT_W-1:0] pre_q, pre_nxt, act_q;
        logic             hit;

        // Select write data or hold for this field's buffered copy.
        always_comb begin
            hit     = wr_en && (wr_sel == 2'(g));
            pre_nxt = hit ? wr_data : pre_q;
        end

        // Buffered copy register.
        always_ff @(posedge clk) begin
            if (!rst_n) pre_q <= RST_VAL;
            else        pre_q <= pre_nxt;
        end

        // Active copy: load on update, or directly for an unbuffered period.
        always_ff @(posedge clk) begin
            if (!rst_n)                                           act_q <= RST_VAL;
            else if (upd)                                         act_q <= pre_nxt;
            else if (g == FLD_PERIOD && !period_buf_en && hit)    act_q <= wr_data;
        end

        assign act[g] = act_q;
    end

    // Repetition register, used directly by the repetition counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        rep_val <= '0;
        else if (wr_en && wr_sel == 2'(FLD_REP))           rep_val <= wr_data[REP_W-1:0];
    end
endmodule

// File: rtl/rtmr_psc.sv
// Prescaler: emits a one-cycle step pulse once every (div + 1) enabled cycles.
// Assumes: restart has priority and returns the count to zero.
module rtmr_psc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] div,
    input  logic         restart,
    output logic         step
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] pcnt;

    // Step when enabled and the divider count has reached its limit.
    assign step = en && (pcnt >= div);

    // Divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (restart) pcnt <= '0;
        else if (en)     pcnt <= step ? '0 : pcnt + ONE;
    end
endmodule

// File: rtl/rtmr_core.sv
// Main counter: up, down or center-aligned over 0..period, flagging each
// end-of-range step (overflow or underflow).
// Assumes: reserved mode behaves as up; direction is up outside center mode.
module rtmr_core
    import rtmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);
    logic dir_dn;
    logic at_top, at_bot;

    // End-of-range detection for the current mode and direction.
    always_comb begin
        at_top = (count >= period);
        at_bot = (count == '0);
        unique case (mode)
            MODE_DOWN:   wrap = step && at_bot;
            MODE_CENTER: wrap = step && (dir_dn ? at_bot : at_top);
            default:     wrap = step && at_top;
        endcase
    end

    // Count and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            dir_dn <= 1'b0;
        end else if (step) begin
            unique case (mode)
                MODE_DOWN: begin
                    count  <= at_bot ? period : count - ONE;
                    dir_dn <= 1'b0;
                end
                MODE_CENTER: begin
                    if (!dir_dn) begin
                        if (at_top) begin
                            count  <= (period == '0) ? '0 : count - ONE;
                            dir_dn <= 1'b1;
                        end else begin
                            count  <= count + ONE;
                        end
                    end else begin
                        if (at_bot) begin
                            count  <= (period == '0) ? '0 : ONE;
                            dir_dn <= 1'b0;
                        end else begin
                            count  <= count - ONE;
                        end
                    end
                end
                default: begin
                    count  <= at_top ? '0 : count + ONE;
                    dir_dn <= 1'b0;
                end
            endcase
        end else if (mode != MODE_CENTER) begin
            dir_dn <= 1'b0;
        end
    end
endmodule

// File: rtl/rtmr_rep.sv
// Repetition counter: counts end-of-range events down to zero, fires on the
// event seen at zero and reloads itself; a forced update also reloads it.
// Assumes: force and wrap in one cycle behave as a reload.
module rtmr_rep #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             force_upd,
    input  logic [REP_W-1:0] rep_val,
    output logic [REP_W-1:0] rep_cnt,
    output logic             fire
);
    localparam logic [REP_W-1:0] ONE = REP_W'(1);

    // Hardware update request from an end-of-range event at zero.
    assign fire = wrap && (rep_cnt == '0);

    // Remaining end-of-range events before the next update.
    always_ff @(posedge clk) begin
        if (!rst_n)                rep_cnt <= '0;
        else if (force_upd || fire) rep_cnt <= rep_val;
        else if (wrap)             rep_cnt <= rep_cnt - ONE;
    end
endmodule

// File: rtl/rep_timer.sv
// Repetition-gated timer top: prescaler, counter, repetition counter and
// buffered registers, plus the sticky update flag.
// Assumes: upd_o is combinational; its effects land on the following edge.
module rep_timer
    import rtmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             period_buf_en,
    input  logic [1:0]       mode,
    input  logic             sw_update,
    input  logic             slave_update,
    input  logic             uif_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o,
    output logic             uif_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] psc_o,
    output logic [CNT_W-1:0] cmp_o
);
    logic [N_BUF-1:0][CNT_W-1:0] act;
    logic [REP_W-1:0]            rep_val;
    logic [REP_W-1:0]            rep_cnt;
    logic                        step, wrap, fire, force_upd;
    cnt_mode_e                   mode_e;

    assign mode_e    = cnt_mode_e'(mode);
    assign force_upd = sw_update || slave_update;
    assign upd_o     = fire || force_upd;
    assign period_o  = act[FLD_PERIOD];
    assign psc_o     = act[FLD_PSC];
    assign cmp_o     = act[FLD_CMP];

    rtmr_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period_buf_en(period_buf_en), .upd(upd_o),
        .act(act), .rep_val(rep_val)
    );

    rtmr_psc #(.W(CNT_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .div(act[FLD_PSC]),
        .restart(upd_o), .step(step)
    );

    rtmr_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_e),
        .period(act[FLD_PERIOD]), .count(count_o), .wrap(wrap)
    );

    rtmr_rep #(.REP_W(REP_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .force_upd(force_upd),
        .rep_val(rep_val), .rep_cnt(rep_cnt), .fire(fire)
    );

    // Sticky update flag; a new update beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       uif_o <= 1'b0;
        else if (upd_o)   uif_o <= 1'b1;
        else if (uif_clr) uif_o <= 1'b0;
    end
endmodule

// File: rtl/rtmr_chk.sv
// Property checker for rep_timer, attached by bind.
module rtmr_chk #(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             period_buf_en,
    input logic             sw_update,
    input logic             slave_update,
    input logic             uif_clr,
    input logic [CNT_W-1:0] count_o,
    input logic             upd_o,
    input logic             uif_o,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] psc_o,
    input logic [CNT_W-1:0] cmp_o,
    input logic [REP_W-1:0] rep_cnt,
    input logic [REP_W-1:0] rep_val
);
    AST_UIF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> uif_o); // R10
    AST_UIF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uif_o && !uif_clr) |=> uif_o); // R10
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count_o)); // R4
    AST_HW_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && !sw_update && !slave_update) |-> (rep_cnt == '0)); // R5
    AST_FORCE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_update || slave_update) && !(wr_en && wr_sel == 2'd3)) |=> (rep_cnt == $past(rep_val))); // R7
    AST_FORCE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_update || slave_update) |-> upd_o); // R7
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_o && !(wr_en && wr_sel == 2'd0 && !period_buf_en)) |=> $stable(period_o)); // R8
    AST_PSC_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |=> ($stable(psc_o) && $stable(cmp_o))); // R8
endmodule

bind rep_timer rtmr_chk #(.CNT_W(CNT_W), .REP_W(REP_W)) u_rtmr_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .period_buf_en(period_buf_en), .sw_update(sw_update),
    .slave_update(slave_update), .uif_clr(uif_clr), .count_o(count_o),
    .upd_o(upd_o), .uif_o(uif_o), .period_o(period_o), .psc_o(psc_o),
    .cmp_o(cmp_o), .rep_cnt(rep_cnt), .rep_val(rep_val)
);

// File: tb/test_rep_timer.sv
`timescale 1ns/1ps
module test_rep_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, wr_en = 1'b0, period_buf_en = 1'b1;
    logic [1:0]  wr_sel = 2'd0, mode = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sw_update = 1'b0, slave_update = 1'b0, uif_clr = 1'b0;
    logic [15:0] count_o, period_o, psc_o, cmp_o;
    logic        upd_o, uif_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rep_timer i_rep_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period_buf_en(period_buf_en), .mode(mode),
        .sw_update(sw_update), .slave_update(slave_update), .uif_clr(uif_clr),
        .count_o(count_o), .upd_o(upd_o), .uif_o(uif_o), .period_o(period_o),
        .psc_o(psc_o), .cmp_o(cmp_o)
    );

    // ---------------- arithmetic reference model ----------------
    logic [15:0] m_cnt, m_pcnt;
    logic [15:0] m_pre [3];
    logic [15:0] m_act [3];
    logic [7:0]  m_rep, m_repreg;
    logic        m_dir, m_uif;
    logic        m_tick, m_wrap, m_upd;

    always_comb begin
        m_tick = cnt_en && (m_pcnt >= m_act[1]);
        if (mode == 2'd1)      m_wrap = m_tick && (m_cnt == 16'd0);
        else if (mode == 2'd2) m_wrap = m_tick && (m_dir ? (m_cnt == 16'd0) : (m_cnt >= m_act[0]));
        else                   m_wrap = m_tick && (m_cnt >= m_act[0]);
        m_upd = (m_wrap && m_rep == 8'd0) || sw_update || slave_update;
    end

    always @(posedge clk) begin
        logic u, t, w;
        logic [15:0] p;
        u = m_upd; t = m_tick; w = m_wrap; p = m_act[0];
        if (!rst_n) begin
            m_cnt = 0; m_pcnt = 0; m_rep = 0; m_repreg = 0; m_dir = 0; m_uif = 0;
            m_pre[0] = 16'hFFFF; m_act[0] = 16'hFFFF;
            for (int i = 1; i < 3; i++) begin m_pre[i] = 0; m_act[i] = 0; end
        end else begin
            if (t) begin
                if (mode == 2'd1) begin
                    m_cnt = (m_cnt == 0) ? p : m_cnt - 1; m_dir = 0;
                end else if (mode == 2'd2) begin
                    if (!m_dir) begin
                        if (m_cnt >= p) begin m_cnt = (p == 0) ? 0 : m_cnt - 1; m_dir = 1; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin m_cnt = (p == 0) ? 0 : 1; m_dir = 0; end
                        else m_cnt = m_cnt - 1;
                    end
                end else begin
                    m_cnt = (m_cnt >= p) ? 0 : m_cnt + 1; m_dir = 0;
                end
            end else if (mode != 2'd2) m_dir = 0;
            if (u) m_pcnt = 0;
            else if (cnt_en) m_pcnt = t ? 0 : m_pcnt + 1;
            if (u && (sw_update || slave_update || m_rep == 0)) m_rep = m_repreg;
            else if (w) m_rep = m_rep - 1;
            for (int i = 0; i < 3; i++) begin
                logic hit;
                hit = wr_en && wr_sel == 2'(i);
                if (hit) m_pre[i] = wr_data;
                if (u) m_act[i] = m_pre[i];
                else if (i == 0 && hit && !period_buf_en) m_act[i] = wr_data;
            end
            if (wr_en && wr_sel == 2'd3) m_repreg = wr_data[7:0];
            if (u) m_uif = 1;
            else if (uif_clr) m_uif = 0;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tag;
        tag = (mode == 2'd1) ? "R2 R4" : (mode == 2'd2) ? "R3 R4" : "R1 R4";
        chk(tag,   "count",  32'(count_o),  32'(m_cnt));
        chk("R5",  "upd",    32'(upd_o),    32'(m_upd));
        chk("R10", "uif",    32'(uif_o),    32'(m_uif));
        chk("R8",  "period", 32'(period_o), 32'(m_act[0]));
        chk("R8",  "psc",    32'(psc_o),    32'(m_act[1]));
        chk("R8",  "cmp",    32'(cmp_o),    32'(m_act[2]));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; cnt_en = 0;
        step(); step();
        rst_n = 1;
    endtask

    // Program all fields, then force an update with the counter stopped.
    task automatic cfg(input logic [1:0] md, input logic [15:0] psc,
                       input logic [15:0] per, input logic [7:0] rep);
        cnt_en = 0; mode = md;
        wr(2'd0, per); wr(2'd1, psc); wr(2'd2, per >> 1); wr(2'd3, 16'(rep));
        sw_update = 1; step(); sw_update = 0;
    endtask

    task automatic count_upd(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (upd_o) cnt++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int ups;
        logic [15:0] held;
        do_reset();
        // R11: reset state
        chk("R11", "count reset",  32'(count_o),  0);
        chk("R11", "uif reset",    32'(uif_o),    0);
        chk("R11", "period reset", 32'(period_o), 32'hFFFF);
        chk("R11", "psc reset",    32'(psc_o),    0);
        chk("R11", "cmp reset",    32'(cmp_o),    0);
        chk("R11", "upd reset",    32'(upd_o),    0);

        // R5: up mode, period 3, prescaler 1, repetition 2 -> update every 24 cycles
        cfg(2'd0, 16'd1, 16'd3, 8'd2);
        cnt_en = 1;
        count_upd(240, ups);
        chk("R5", "up updates in 240 cycles", 32'(ups), 10);

        // R6: center mode, period 3, prescaler 0, repetition 1 -> update every 6 cycles
        do_reset();
        cfg(2'd2, 16'd0, 16'd3, 8'd1);
        cnt_en = 1;
        count_upd(60, ups);
        chk("R6", "center updates in 60 cycles", 32'(ups), 10);

        // R1: up mode with repetition 1 for contrast: 5 updates in 40 cycles (period 3, psc 0)
        do_reset();
        cfg(2'd0, 16'd0, 16'd3, 8'd1);
        cnt_en = 1;
        count_upd(40, ups);
        chk("R1 R5", "up updates in 40 cycles", 32'(ups), 5);

        // R4: counter holds with enable low
        cnt_en = 0;
        step();
        held = count_o;
        repeat (10) step();
        chk("R4", "count held while disabled", 32'(count_o), 32'(held));
        cnt_en = 1;

        // R8: buffered period write leaves the active period until an update
        period_buf_en = 1;
        cfg(2'd0, 16'd0, 16'd3, 8'd3);
        cnt_en = 1;
        wr(2'd0, 16'd5);
        chk("R8", "period after buffered write", 32'(period_o), 3);
        while (!upd_o) step();
        step();
        chk("R8", "period after update", 32'(period_o), 5);

        // R9: unbuffered period write applies at once
        period_buf_en = 0;
        wr(2'd0, 16'd2);
        chk("R9", "period after direct write", 32'(period_o), 2);
        period_buf_en = 1;

        // R7: slave request forces an update mid-count
        repeat (3) step();
        slave_update = 1;
        #1;
        chk("R7", "upd on slave request", 32'(upd_o), 1);
        step();
        slave_update = 0;
        repeat (20) step();

        // R10: clear, then clear together with an update
        cnt_en = 0;
        step();
        uif_clr = 1; step(); uif_clr = 0;
        chk("R10", "uif after clear", 32'(uif_o), 0);
        uif_clr = 1; sw_update = 1; step(); uif_clr = 0; sw_update = 0;
        chk("R10", "uif when update meets clear", 32'(uif_o), 1);

        // Sweep: all modes x prescaler x period x repetition, with mid-run writes
        for (int md = 0; md < 3; md++)
            for (int ps = 0; ps < 3; ps++)
                for (int pr = 1; pr < 4; pr++)
                    for (int rp = 0; rp < 3; rp++) begin
                        period_buf_en = ((ps + rp) % 2 == 0);
                        cfg(2'(md), 16'(ps), 16'(pr), 8'(rp));
                        cnt_en = 1;
                        repeat (30) step();
                        wr(2'd0, 16'(pr + 1));
                        wr(2'd2, 16'(pr));
                        repeat (30) step();
                        if (rp == 1) begin
                            sw_update = 1; step(); sw_update = 0;
                        end
                        repeat (10) step();
                    end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule